// File: doc/BRIEF.md
# Glitch-Free Master Clock Selector with Crystal Failure Fallback

This block picks the master clock of a chip from four sources: an external crystal oscillator, an externally supplied user clock, a fast internal RC oscillator (nominally 16 MHz) and a slow internal RC oscillator (nominally 128 kHz). Software asks for a source through a small register bus that runs on the fast internal RC clock. The request is only committed once the chosen source reports ready. The handover then disables the old clock on its own falling edge and enables the new one on its falling edge, so the output never carries a runt pulse. Out of reset the block runs from the fast RC with a prescaler exponent of 3, which gives the 2 MHz start-up rate.

A power-of-two prescaler turns the master clock into a one-cycle strobe for the core and the peripherals. A per-peripheral gate mask turns that strobe into individual clock enables. A failure monitor counts fast-RC cycles between edges of the crystal. If it sees no edge for a fixed number of cycles while it is armed, it latches a failure flag and forces the fast RC with exponent 3. It can also raise an interrupt. Only reset clears the flag, and the crystal cannot be chosen again until then.

Top module: `clk_switch`

## Requirements
- R1: After reset the master clock comes from the fast RC. The prescaler exponent reads 3, every gate bit reads 1, the monitor and the interrupt are disabled, the failure flag is 0 and `irq` is low.
- R2: Register map, selected by `bus_addr`. Address 0: a write of bits [1:0] requests a source (0 crystal, 1 external user clock, 2 fast RC, 3 slow RC). A read returns the committed source in [1:0], the requested source in [3:2] and a busy flag in bit 7. Address 1 holds the prescaler exponent in bits [2:0]. Address 2 holds the gate mask. Address 3 holds the monitor enable in bit 0 and the interrupt enable in bit 1, and reads the failure flag in bit 7.
- R3: While the requested source is not ready, the request is held. The committed source is unchanged, busy reads 1 and `clk_master` keeps the period of the old source.
- R4: Once the requested source is ready, `clk_master` takes the period of that source and busy returns to 0.
- R5: No high or low phase of `clk_master` is ever shorter than the shortest half period among the sources.
- R6: With exponent n, `div_tick` is high in exactly one of every 2^n cycles of `clk_master`.
- R7: `periph_ce[i]` pulses together with `div_tick` when gate bit i is 1, and stays low when it is 0.
- R8: With the monitor enabled, a crystal with no edge for FAIL_LIMIT fast-RC cycles sets the failure flag. The committed and requested source both become the fast RC and the exponent becomes 3.
- R9: `irq` is high exactly while the failure flag is set and the interrupt enable is 1.
- R10: After a failure, a write that requests the crystal leaves the requested source unchanged. Only reset clears the failure flag.
- R11: With the monitor disabled, a stopped crystal never sets the failure flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | External crystal oscillator clock, watched by the monitor |
| clk_ext | input | 1 | External user clock |
| clk_rc16 | input | 1 | Fast internal RC clock; also clocks the register bus and the monitor |
| clk_rc128 | input | 1 | Slow internal RC clock |
| rdy_xtal | input | 1 | Crystal ready flag (asynchronous) |
| rdy_ext | input | 1 | External user clock ready flag (asynchronous) |
| rdy_rc16 | input | 1 | Fast RC ready flag (asynchronous) |
| rdy_rc128 | input | 1 | Slow RC ready flag (asynchronous) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled on `clk_rc16` |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| clk_master | output | 1 | Selected master clock |
| div_tick | output | 1 | Prescaler strobe in the `clk_master` domain |
| periph_ce | output | NPERIPH | Gated per-peripheral clock enables |
| irq | output | 1 | Failure interrupt |

## Verification
The bench uses the default build: eight peripheral gates, a maximum exponent of 7 and a failure limit of 32 fast-RC cycles. Each source clock has its own distinct period, so every switch can be identified from the measured period of `clk_master`. A 32-cycle limit is well above the crystal's edge spacing once that edge is synchronized. It lets a failure be provoked and detected within a few hundred cycles, and it still rules out false alarms while the crystal runs. The exponents under test divide a 64-cycle window exactly, so the strobe and enable counts have exact expected values.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
   localparam int NSRC = 4;
   localparam logic [1:0] SRC_XTAL  = 2'd0;
   localparam logic [1:0] SRC_EXT   = 2'd1;
   localparam logic [1:0] SRC_RC16  = 2'd2;
   localparam logic [1:0] SRC_RC128 = 2'd3;
   localparam logic [1:0] REG_SRC  = 2'd0;
   localparam logic [1:0] REG_DIV  = 2'd1;
   localparam logic [1:0] REG_GATE = 2'd2;
   localparam logic [1:0] REG_MON  = 2'd3;
   localparam int FALLBACK_EXP = 3;
endpackage

// File: rtl/clksw_src_gate.sv
`timescale 1ns/1ps
// One leg of the clock selector: the request is synchronized with two rising-edge
// flops, then the enable changes on a falling edge, while the leg clock is low.
module clksw_src_gate (
   input  logic clk_src,
   input  logic rst_n,
   input  logic kill,
   input  logic want,
   output logic en,
   output logic gclk
);
   logic s1, s2;

   always_ff @(posedge clk_src or negedge rst_n or posedge kill) begin
      if (!rst_n || kill) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= want;
         s2 <= s1;
      end
   end

   always_ff @(negedge clk_src or negedge rst_n or posedge kill) begin
      if (!rst_n || kill) en <= 1'b0;
      else                en <= s2;
   end

   assign gclk = clk_src & en;
endmodule

// File: rtl/clksw_monitor.sv
`timescale 1ns/1ps
// Crystal activity watcher: toggles on each crystal edge, brings the toggle into
// the reference domain, and counts reference cycles with no change.
module clksw_monitor #(
   parameter int LIMIT = 32
) (
   input  logic clk_ref,
   input  logic clk_watch,
   input  logic rst_n,
   input  logic enable,
   output logic fail,
   output logic fail_pulse
);
   localparam int CW = $clog2(LIMIT + 1);

   logic          tog;
   logic [2:0]    sync_q;
   logic [CW-1:0] idle_cnt;
   logic          seen_edge, trip;

   always_ff @(posedge clk_watch or negedge rst_n) begin
      if (!rst_n) tog <= 1'b0;
      else        tog <= ~tog;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[1:0], tog};
   end

   assign seen_edge = sync_q[2] ^ sync_q[1];
   assign trip      = enable && (idle_cnt == CW'(LIMIT));

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)                  idle_cnt <= '0;
      else if (!enable || seen_edge) idle_cnt <= '0;
      else if (idle_cnt != CW'(LIMIT)) idle_cnt <= idle_cnt + 1'b1;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)    fail <= 1'b0;
      else if (trip) fail <= 1'b1;
   end

   assign fail_pulse = trip & ~fail;
endmodule

// File: rtl/clksw_prescale.sv
`timescale 1ns/1ps
// Power-of-two strobe generator in the master clock domain, with per-peripheral gating.
module clksw_prescale #(
   parameter int NCE     = 8,
   parameter int MAX_EXP = 7
) (
   input  logic                            clk_m,
   input  logic                            rst_n,
   input  logic [$clog2(MAX_EXP+1)-1:0]    exp_in,
   input  logic [NCE-1:0]                  gate_in,
   output logic                            tick,
   output logic [NCE-1:0]                  ce
);
   localparam int EXPW = $clog2(MAX_EXP + 1);

   logic [EXPW-1:0]    e1, e2;
   logic [NCE-1:0]     g1, g2;
   logic [MAX_EXP-1:0] cnt;
   logic [MAX_EXP:0]   mask_w;
   logic               hit;

   always_ff @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         e1 <= EXPW'(clksw_pkg::FALLBACK_EXP);
         e2 <= EXPW'(clksw_pkg::FALLBACK_EXP);
         g1 <= '1;
         g2 <= '1;
      end else begin
         e1 <= exp_in;
         e2 <= e1;
         g1 <= gate_in;
         g2 <= g1;
      end
   end

   assign mask_w = ({{MAX_EXP{1'b0}}, 1'b1} << e2) - 1'b1;
   assign hit    = &(cnt | ~mask_w[MAX_EXP-1:0]);

   always_ff @(posedge clk_m or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
         ce   <= '0;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= hit;
         ce   <= g2 & {NCE{hit}};
      end
   end
endmodule

// File: rtl/clk_switch.sv
`timescale 1ns/1ps
module clk_switch #(
   parameter int NPERIPH    = 8,
   parameter int MAX_EXP    = 7,
   parameter int FAIL_LIMIT = 32
) (
   input  logic               clk_xtal,
   input  logic               clk_ext,
   input  logic               clk_rc16,
   input  logic               clk_rc128,
   input  logic               rdy_xtal,
   input  logic               rdy_ext,
   input  logic               rdy_rc16,
   input  logic               rdy_rc128,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               clk_master,
   output logic               div_tick,
   output logic [NPERIPH-1:0] periph_ce,
   output logic               irq
);
   import clksw_pkg::*;

   localparam int EXPW = $clog2(MAX_EXP + 1);

   generate
      if (NPERIPH < 1 || NPERIPH > 8) begin : g_bad_nce
         $error("NPERIPH must lie in 1..8");
      end
      if (MAX_EXP < FALLBACK_EXP || MAX_EXP > 7) begin : g_bad_exp
         $error("MAX_EXP must lie in 3..7");
      end
      if (FAIL_LIMIT < 8) begin : g_bad_lim
         $error("FAIL_LIMIT must be at least 8");
      end
   endgenerate

   logic [NSRC-1:0] src_clk, src_rdy;
   logic [NSRC-1:0] rdy_s1, rdy_s2;
   logic [NSRC-1:0] en_q, en_s1, en_s2, gclk, want, kill, others;
   logic [1:0]      req_src, cur_src;
   logic [EXPW-1:0] exp_q;
   logic [NPERIPH-1:0] gate_q;
   logic            mon_en, irq_en, fail_q, fail_pulse, busy;

   assign src_clk = {clk_rc128, clk_rc16, clk_ext, clk_xtal};
   assign src_rdy = {rdy_rc128, rdy_rc16, rdy_ext, rdy_xtal};

   always_ff @(posedge clk_rc16 or negedge rst_n) begin
      if (!rst_n) begin
         rdy_s1 <= '0;
         rdy_s2 <= '0;
         en_s1  <= '0;
         en_s2  <= '0;
      end else begin
         rdy_s1 <= src_rdy;
         rdy_s2 <= rdy_s1;
         en_s1  <= en_q;
         en_s2  <= en_s1;
      end
   end

   // register writes, commit of a ready request, forced fallback on failure
   always_ff @(posedge clk_rc16 or negedge rst_n) begin
      if (!rst_n) begin
         req_src <= SRC_RC16;
         cur_src <= SRC_RC16;
         exp_q   <= EXPW'(FALLBACK_EXP);
         gate_q  <= '1;
         mon_en  <= 1'b0;
         irq_en  <= 1'b0;
      end else if (fail_pulse) begin
         req_src <= SRC_RC16;
         cur_src <= SRC_RC16;
         exp_q   <= EXPW'(FALLBACK_EXP);
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               REG_SRC: begin
                  if (!(fail_q && bus_wdata[1:0] == SRC_XTAL)) req_src <= bus_wdata[1:0];
               end
               REG_DIV: begin
                  if (32'(bus_wdata[EXPW-1:0]) > MAX_EXP) exp_q <= EXPW'(MAX_EXP);
                  else                                    exp_q <= bus_wdata[EXPW-1:0];
               end
               REG_GATE: gate_q <= bus_wdata[NPERIPH-1:0];
               default: begin
                  mon_en <= bus_wdata[0];
                  irq_en <= bus_wdata[1];
               end
            endcase
         end
         if (req_src != cur_src && rdy_s2[req_src] && !(fail_q && req_src == SRC_XTAL))
            cur_src <= req_src;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_leg
         assign others[gi] = |(en_q & ~(NSRC'(1) << gi));
         assign want[gi]   = (cur_src == 2'(gi)) && !others[gi];
         if (gi == SRC_XTAL) begin : g_watched
            assign kill[gi] = fail_q;
         end else begin : g_plain
            assign kill[gi] = 1'b0;
         end
         clksw_src_gate u_leg (
            .clk_src (src_clk[gi]),
            .rst_n   (rst_n),
            .kill    (kill[gi]),
            .want    (want[gi]),
            .en      (en_q[gi]),
            .gclk    (gclk[gi])
         );
      end
   endgenerate

   assign clk_master = |gclk;

   clksw_monitor #(.LIMIT(FAIL_LIMIT)) u_mon (
      .clk_ref    (clk_rc16),
      .clk_watch  (clk_xtal),
      .rst_n      (rst_n),
      .enable     (mon_en),
      .fail       (fail_q),
      .fail_pulse (fail_pulse)
   );

   clksw_prescale #(.NCE(NPERIPH), .MAX_EXP(MAX_EXP)) u_div (
      .clk_m   (clk_master),
      .rst_n   (rst_n),
      .exp_in  (exp_q),
      .gate_in (gate_q),
      .tick    (div_tick),
      .ce      (periph_ce)
   );

   assign busy = (req_src != cur_src) || !en_s2[cur_src];
   assign irq  = fail_q & irq_en;

   always_comb begin
      case (bus_addr)
         REG_SRC:  bus_rdata = {busy, 3'b000, req_src, cur_src};
         REG_DIV:  bus_rdata = 8'(exp_q);
         REG_GATE: bus_rdata = 8'(gate_q);
         default:  bus_rdata = {fail_q, 5'b00000, irq_en, mon_en};
      endcase
   end
endmodule

// File: rtl/clk_switch_chk.sv
`timescale 1ns/1ps
module clk_switch_chk (
   input logic       clk_rc16,
   input logic       rst_n,
   input logic [3:0] en_q,
   input logic [3:0] rdy_s2,
   input logic [1:0] cur_src,
   input logic [2:0] exp_q,
   input logic       fail_q,
   input logic       irq
);
   // R5: legs never overlap
   assert_legs_exclusive_R5: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      $onehot0(en_q));

   // R3: a new committed source must have been seen ready
   assert_commit_ready_R3: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      (!$stable(cur_src) && $stable(fail_q)) |-> |($past(rdy_s2) & (4'b0001 << cur_src)));

   // R8: failure lands on the fast RC with exponent 3
   assert_fallback_R8: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      $rose(fail_q) |-> (cur_src == 2'd2 && exp_q == 3'd3));

   // R10: flag is sticky and the crystal leg stays off
   assert_fail_sticky_R10: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      fail_q |=> fail_q);
   assert_xtal_off_R10: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      fail_q |-> !en_q[0]);

   // R9: no interrupt without a failure
   assert_irq_cause_R9: assert property (@(posedge clk_rc16) disable iff (!rst_n)
      irq |-> fail_q);
endmodule

bind clk_switch clk_switch_chk u_chk (
   .clk_rc16 (clk_rc16),
   .rst_n    (rst_n),
   .en_q     (en_q),
   .rdy_s2   (rdy_s2),
   .cur_src  (cur_src),
   .exp_q    (exp_q),
   .fail_q   (fail_q),
   .irq      (irq)
);

// File: tb/tb_clk_switch.sv
`timescale 1ns/1ps
module tb_clk_switch;
   logic clk_xtal = 0, clk_ext = 0, clk_rc16 = 0, clk_rc128 = 0;
   logic rdy_xtal = 1, rdy_ext = 1, rdy_rc16 = 1, rdy_rc128 = 1;
   logic rst_n = 0, bus_wr = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic clk_master, div_tick, irq;
   logic [7:0] periph_ce;
   logic xtal_run = 1;

   int n_chk = 0, n_bad = 0;
   bit track = 0;
   realtime last_edge = 0;
   int min_ps = 1000000;

   clk_switch dut (.*);

   always #2.5 clk_rc16 = ~clk_rc16;           // 200 MHz
   always begin #4; if (xtal_run) clk_xtal = ~clk_xtal; end
   always #6 clk_ext = ~clk_ext;
   always #20 clk_rc128 = ~clk_rc128;

   always @(clk_master) begin
      if (track) begin
         int w;
         w = int'(($realtime - last_edge) * 1000.0);
         if (w < min_ps) min_ps = w;
      end
      last_edge = $realtime;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk_rc16);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk_rc16);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk_rc16);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic period_ps(output int p);
      realtime t1;
      repeat (3) @(posedge clk_master);
      t1 = $realtime;
      @(posedge clk_master);
      p = int'(($realtime - t1) * 1000.0);
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int k = 0; k < 400; k++) begin
         rd(0, s);
         if (!s[7]) break;
      end
   endtask

   task automatic count_ticks(output int t, output int c0, output int c1);
      t = 0; c0 = 0; c1 = 0;
      repeat (8) @(posedge clk_master);
      for (int k = 0; k < 64; k++) begin
         @(negedge clk_master);
         t  += int'(div_tick);
         c0 += int'(periph_ce[0]);
         c1 += int'(periph_ce[1]);
      end
   endtask

   task automatic t_reset();
      logic [7:0] d; int p;
      rd(0, d); chk("R1 source status", int'(d[3:0]), 4'b1010);
      rd(1, d); chk("R1 exponent", int'(d), 3);
      rd(2, d); chk("R1 gates", int'(d), 8'hFF);
      rd(3, d); chk("R1 monitor reg", int'(d), 0);
      chk("R1 irq", int'(irq), 0);
      period_ps(p); chk("R1 fast RC period", p, 5000);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(2, 8'h5A); rd(2, d); chk("R2 gate readback", int'(d), 8'h5A);
      wr(1, 8'h06); rd(1, d); chk("R2 exponent readback", int'(d), 6);
      wr(3, 8'h02); rd(3, d); chk("R2 monitor readback", int'(d), 2);
      wr(3, 8'h00); wr(2, 8'hFF);
   endtask

   task automatic t_prescale();
      int t, c0, c1;
      wr(2, 8'h05);
      wr(1, 0); count_ticks(t, c0, c1);
      chk("R6 exp0 ticks", t, 64);
      chk("R7 gated-on ce", c0, 64);
      chk("R7 gated-off ce", c1, 0);
      wr(1, 2); count_ticks(t, c0, c1); chk("R6 exp2 ticks", t, 16);
      wr(1, 3); count_ticks(t, c0, c1); chk("R6 exp3 ticks", t, 8);
      chk("R7 ce follows tick", c0, 8);
      wr(2, 8'hFF);
   endtask

   task automatic t_switch();
      logic [7:0] d; int p;
      wr(0, 0); wait_idle();
      rd(0, d); chk("R4 crystal committed", int'(d[3:0]), 4'b0000);
      period_ps(p); chk("R4 crystal period", p, 8000);
      wr(0, 3); wait_idle();
      period_ps(p); chk("R4 slow RC period", p, 40000);
      rdy_ext = 0;
      wr(0, 1);
      repeat (60) @(posedge clk_rc16);
      rd(0, d); chk("R3 held status", int'(d), 8'h87);
      period_ps(p); chk("R3 old period kept", p, 40000);
      rdy_ext = 1;
      wait_idle();
      rd(0, d); chk("R4 ext committed", int'(d), 8'h05);
      period_ps(p); chk("R4 ext period", p, 12000);
      wr(0, 2); wait_idle();
      period_ps(p); chk("R4 back to fast RC", p, 5000);
   endtask

   task automatic t_mon_off();
      logic [7:0] d;
      @(negedge clk_xtal); xtal_run = 0;
      repeat (120) @(posedge clk_rc16);
      rd(3, d); chk("R11 no failure when disarmed", int'(d[7]), 0);
      xtal_run = 1;
   endtask

   task automatic t_failure();
      logic [7:0] d; int p, t, c0, c1;
      wr(1, 0);
      wr(0, 0); wait_idle();
      wr(3, 8'h03);
      repeat (60) @(posedge clk_rc16);
      rd(3, d); chk("R8 no false alarm", int'(d[7]), 0);
      @(negedge clk_xtal); xtal_run = 0;
      repeat (80) @(posedge clk_rc16);
      rd(3, d); chk("R8 failure flag", int'(d[7]), 1);
      chk("R9 irq raised", int'(irq), 1);
      rd(0, d); chk("R8 forced source", int'(d[3:0]), 4'b1010);
      rd(1, d); chk("R8 forced exponent", int'(d), 3);
      period_ps(p); chk("R8 fallback period", p, 5000);
      count_ticks(t, c0, c1); chk("R8 divide by 8", t, 8);
      xtal_run = 1;
      wr(0, 0);
      repeat (20) @(posedge clk_rc16);
      rd(0, d); chk("R10 crystal request ignored", int'(d[3:0]), 4'b1010);
      wr(3, 8'h01);
      chk("R9 irq masked", int'(irq), 0);
      rd(3, d); chk("R10 flag sticky", int'(d[7]), 1);
   endtask

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk_rc16);
      #1 rst_n = 1;
      repeat (20) @(posedge clk_rc16);
      track = 1;
      t_reset();
      t_regs();
      t_prescale();
      t_switch();
      t_mon_off();
      t_failure();
      chk("R5 narrowest master phase >= 2500ps", int'(min_ps >= 2500), 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule